// File: doc/BRIEF.md
# Packet Command Sequencer

This block stores two 64-bit transmit commands behind a 32-bit register bus. It hands them to a downstream packet engine in a repeating pattern over a valid/ready output. Software loads the two command slots and picks a pattern with the mode register. It then writes a non-zero command count, and that write alone starts the run. Each accepted handshake uses one command and lowers the count by one. When the count reaches zero the output goes idle.

There are two patterns. In paired mode each frame costs two commands: a header command from slot 1, then a frame command from slot 2. In triple mode each frame costs three commands: slot 1, then slot 2 twice, so that a frame too large for one request goes out in two halves. A count of 20 therefore moves ten frames in paired mode, and a count of 30 moves ten frames in triple mode. Two identification words let software confirm that it found the block. A readout normally holds one instance per half, placed 0x100 bytes apart.

Top module: `pktcmd_sequencer`

## Requirements
- R1: A read at byte offset 0x00 returns 0xC0DE0001 and a read at 0x04 returns 0x636D6467. Writes to these two offsets change neither value.
- R2: While the block is idle, writes to 0x08/0x0C set the low/high 32 bits of slot 1, and writes to 0x10/0x14 set the low/high 32 bits of slot 2. Each of these offsets reads back what was written.
- R3: Writing N > 0 to offset 0x18 starts a run in which exactly N commands are accepted. After the last one, cmd_valid is low.
- R4: With bit 31 of the mode register (offset 0x1C) clear, accepted commands follow slot1, slot2, slot1, slot2, ...
- R5: With mode bit 31 set, accepted commands follow slot1, slot2, slot2, slot1, slot2, slot2, ...
- R6: A command is accepted only in a cycle where cmd_valid and cmd_ready are both high. While cmd_valid is high and cmd_ready is low, cmd_word and cmd_valid hold.
- R7: Offset 0x18 reads back the number of commands still to send. The busy output is high exactly when that number is non-zero.
- R8: While busy, writes to the slot offsets and to the mode offset are ignored.
- R9: Writing 0 to offset 0x18 during a run ends it. From the next cycle cmd_valid and busy are low and the counter reads 0.
- R10: Every write to offset 0x18 resets the pattern position, so the next command offered is slot 1, even in the middle of a run.
- R11: Reads at offsets 0x20 and above, and at any address whose two low bits are non-zero, return 0. Writes there change nothing.
- R12: After reset the block is idle, the counter reads 0 and both slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken at the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address inside the block window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Downstream accepts the offered command |
| cmd_word | output | 64 | Offered command |
| busy | output | 1 | Remaining count is non-zero |

## Verification
A register write takes effect at the rising edge that samples bus_wr. The resulting busy, cmd_valid, cmd_word and read-back values are therefore visible straight after that edge. Reads are combinational and due in the same cycle as the address. A handshake moves cmd_word and the count at the edge where valid and ready are both high. The bench drives every input at falling edges and samples 1 ns later. Each check thus sees exactly the state left by the preceding rising edge. It sweeps counts 1 to 7 in both modes under three ready patterns, and predicts each accepted command from its index modulo 2 or 3.

// File: rtl/pktcmd_pkg.sv
package pktcmd_pkg;
   localparam int BUS_W = 32;
   localparam int CMD_W = 2 * BUS_W;

   typedef enum logic [3:0] {
      SEL_ID0, SEL_ID1, SEL_S1L, SEL_S1H, SEL_S2L, SEL_S2H,
      SEL_CNT, SEL_MODE, SEL_NONE
   } reg_sel_e;

   // word index 0..7 inside the first 32 bytes, aligned accesses only
   function automatic reg_sel_e decode_word(input logic aligned, input logic hi_zero,
                                            input logic [2:0] idx);
      if (!aligned || !hi_zero) return SEL_NONE;
      case (idx)
         3'd0: return SEL_ID0;
         3'd1: return SEL_ID1;
         3'd2: return SEL_S1L;
         3'd3: return SEL_S1H;
         3'd4: return SEL_S2L;
         3'd5: return SEL_S2H;
         3'd6: return SEL_CNT;
         default: return SEL_MODE;
      endcase
   endfunction
endpackage

// File: rtl/pktcmd_regs.sv
module pktcmd_regs
   import pktcmd_pkg::*;
#(
   parameter int          ADDR_W = 8,
   parameter int          CNT_W  = 32,
   parameter logic [31:0] ID0    = 32'hC0DE0001,
   parameter logic [31:0] ID1    = 32'h636D6467,
   parameter int          MODE_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              busy,
   input  logic [CNT_W-1:0]  cnt,
   output logic [BUS_W-1:0]  rdata,
   output logic [CMD_W-1:0]  slot1,
   output logic [CMD_W-1:0]  slot2,
   output logic              triple,
   output logic              cnt_load
);
   reg_sel_e         sel;
   logic [BUS_W-1:0] mode_q;
   logic             cfg_wr;

   assign sel      = decode_word(addr[1:0] == 2'b00, addr[ADDR_W-1:5] == '0, addr[4:2]);
   assign cfg_wr   = wr && !busy;
   assign cnt_load = wr && (sel == SEL_CNT);
   assign triple   = mode_q[MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot1  <= '0;
         slot2  <= '0;
         mode_q <= '0;
      end else if (cfg_wr) begin
         case (sel)
            SEL_S1L:  slot1[BUS_W-1:0]     <= wdata;
            SEL_S1H:  slot1[CMD_W-1:BUS_W] <= wdata;
            SEL_S2L:  slot2[BUS_W-1:0]     <= wdata;
            SEL_S2H:  slot2[CMD_W-1:BUS_W] <= wdata;
            SEL_MODE: mode_q               <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_ID0:  rdata = ID0;
         SEL_ID1:  rdata = ID1;
         SEL_S1L:  rdata = slot1[BUS_W-1:0];
         SEL_S1H:  rdata = slot1[CMD_W-1:BUS_W];
         SEL_S2L:  rdata = slot2[BUS_W-1:0];
         SEL_S2H:  rdata = slot2[CMD_W-1:BUS_W];
         SEL_CNT:  rdata = BUS_W'(cnt);
         SEL_MODE: rdata = mode_q;
         default:  rdata = '0;
      endcase
   end

   // configuration must not move during a run
   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr) |=> ($stable(slot1) && $stable(slot2) && $stable(mode_q)));
endmodule

// File: rtl/pktcmd_counter.sv
module pktcmd_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             fire,
   output logic [CNT_W-1:0] cnt,
   output logic             busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (fire) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load) |=> (cnt == $past(cnt) - 1'b1));
   assert_load_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/pktcmd_stepper.sv
module pktcmd_stepper #(
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       fire,
   input  logic       triple,
   input  logic       busy,
   output logic [1:0] pos
);
   logic [1:0] pos_nxt;

   generate
      if (TRIPLE_EN) begin : g_triple
         always_comb begin
            case (pos)
               2'd0:    pos_nxt = 2'd1;
               2'd1:    pos_nxt = triple ? 2'd2 : 2'd0;
               default: pos_nxt = 2'd0;
            endcase
         end
      end else begin : g_pair
         always_comb pos_nxt = (pos == 2'd0) ? 2'd1 : 2'd0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= 2'd0;
      else if (restart) pos <= 2'd0;
      else if (fire)    pos <= pos_nxt;
   end

   assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n) pos != 2'd3);
   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pos == 2'd0));
   assert_pair_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !triple) |-> (pos != 2'd2));
endmodule

// File: rtl/pktcmd_sequencer.sv
module pktcmd_sequencer
   import pktcmd_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          CNT_W     = 32,
   parameter bit          TRIPLE_EN = 1'b1,
   parameter logic [31:0] ID0       = 32'hC0DE0001,
   parameter logic [31:0] ID1       = 32'h636D6467
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [63:0]       cmd_word,
   output logic              busy
);
   localparam int MODE_BIT = BUS_W - 1;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must cover at least the 32-byte register window");
      end
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic [CMD_W-1:0] slot1, slot2;
   logic             triple, cnt_load, fire;
   logic [CNT_W-1:0] cnt;
   logic [1:0]       pos;

   pktcmd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID0(ID0), .ID1(ID1), .MODE_BIT(MODE_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .busy(busy), .cnt(cnt), .rdata(bus_rdata), .slot1(slot1), .slot2(slot2),
      .triple(triple), .cnt_load(cnt_load)
   );

   pktcmd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]),
      .fire(fire), .cnt(cnt), .busy(busy)
   );

   pktcmd_stepper #(.TRIPLE_EN(TRIPLE_EN)) u_step (
      .clk(clk), .rst_n(rst_n), .restart(cnt_load), .fire(fire),
      .triple(triple), .busy(busy), .pos(pos)
   );

   assign cmd_valid = busy;
   assign fire      = cmd_valid && cmd_ready;
   assign cmd_word  = (pos == 2'd0) ? slot1 : slot2;

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && !cnt_load) |=> (cmd_valid && $stable(cmd_word)));
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_load && bus_wdata[CNT_W-1:0] == '0) |=> !cmd_valid);
endmodule

// File: tb/tb_pktcmd_sequencer.sv
module tb_pktcmd_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cmd_valid, cmd_ready = 1'b0, busy;
   logic [63:0] cmd_word;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   localparam logic [63:0] A = 64'h6A00_4000_0000_0001;
   localparam logic [63:0] B = 64'h6B08_2000_0000_00FF;

   pktcmd_sequencer dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_word(cmd_word), .busy(busy)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic load_slots(input logic [63:0] s1, input logic [63:0] s2);
      wr(8'h08, s1[31:0]); wr(8'h0C, s1[63:32]);
      wr(8'h10, s2[31:0]); wr(8'h14, s2[63:32]);
   endtask

   function automatic bit ready_at(input int pat, input int c);
      case (pat)
         0: return 1'b1;
         1: return (c % 3) != 2;
         default: return (c % 2) == 1;
      endcase
   endfunction

   // runs until cmd_valid drops; compares every accepted command to its index
   task automatic run_and_check(input int n, input bit trip, input int pat);
      int got = 0;
      bit held = 1'b0;
      logic [63:0] prev = '0;
      logic [63:0] exp;
      for (int c = 0; c < n * 4 + 20; c++) begin
         @(negedge clk);
         cmd_ready = ready_at(pat, c);
         #1;
         if (!cmd_valid) break;
         if (held) check(cmd_word == prev, "R6", cmd_word, prev);
         if (cmd_ready) begin
            exp = trip ? (((got % 3) == 0) ? A : B) : (((got % 2) == 0) ? A : B);
            check(cmd_word == exp, trip ? "R5" : "R4", cmd_word, exp);
            got = got + 1;
            held = 1'b0;
         end else begin
            held = 1'b1;
            prev = cmd_word;
         end
      end
      cmd_ready = 1'b0;
      check(got == n, "R3", 64'(got), 64'(n));
      check(busy == 1'b0, "R7", 64'(busy), 64'd0);
   endtask

   task automatic consume(input int k);
      @(negedge clk);
      cmd_ready = 1'b1;
      repeat (k) @(negedge clk);
      cmd_ready = 1'b0;
      #1;
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      check(busy == 1'b0 && cmd_valid == 1'b0, "R12", 64'({busy, cmd_valid}), 64'd0);
      rd(8'h18, d); check(d == 0, "R12", 64'(d), 64'd0);
      rd(8'h08, d); check(d == 0, "R12", 64'(d), 64'd0);
      rd(8'h14, d); check(d == 0, "R12", 64'(d), 64'd0);

      // R1 identification words
      rd(8'h00, d); check(d == 32'hC0DE0001, "R1", 64'(d), 64'hC0DE0001);
      rd(8'h04, d); check(d == 32'h636D6467, "R1", 64'(d), 64'h636D6467);
      wr(8'h00, 32'h1234_5678); wr(8'h04, 32'h0);
      rd(8'h00, d); check(d == 32'hC0DE0001, "R1", 64'(d), 64'hC0DE0001);
      rd(8'h04, d); check(d == 32'h636D6467, "R1", 64'(d), 64'h636D6467);

      // R2 slot read-back
      load_slots(A, B);
      rd(8'h08, d); check(d == A[31:0], "R2", 64'(d), 64'(A[31:0]));
      rd(8'h0C, d); check(d == A[63:32], "R2", 64'(d), 64'(A[63:32]));
      rd(8'h10, d); check(d == B[31:0], "R2", 64'(d), 64'(B[31:0]));
      rd(8'h14, d); check(d == B[63:32], "R2", 64'(d), 64'(B[63:32]));

      // R11 unmapped and misaligned
      rd(8'h20, d); check(d == 0, "R11", 64'(d), 64'd0);
      rd(8'hFC, d); check(d == 0, "R11", 64'(d), 64'd0);
      rd(8'h0A, d); check(d == 0, "R11", 64'(d), 64'd0);
      wr(8'h0A, 32'hDEAD_BEEF); wr(8'h1A, 32'd5);
      rd(8'h0C, d); check(d == A[63:32], "R11", 64'(d), 64'(A[63:32]));
      check(busy == 1'b0, "R11", 64'(busy), 64'd0);

      // sweep counts, both modes, three ready patterns
      for (int m = 0; m < 2; m++) begin
         wr(8'h1C, m[0] ? 32'h8000_0000 : 32'h0);
         for (int pat = 0; pat < 3; pat++) begin
            for (int n = 1; n <= 7; n++) begin
               wr(8'h18, 32'(n));
               check(cmd_valid == 1'b1, "R3", 64'(cmd_valid), 64'd1);
               run_and_check(n, m[0], pat);
            end
         end
      end

      // R7 remaining count readback (pair mode)
      wr(8'h1C, 32'h0);
      wr(8'h18, 32'd10);
      rd(8'h18, d); check(d == 10, "R7", 64'(d), 64'd10);
      consume(3);
      rd(8'h18, d); check(d == 7, "R7", 64'(d), 64'd7);
      check(busy == 1'b1, "R7", 64'(busy), 64'd1);
      // R9 abort
      wr(8'h18, 32'd0);
      check(cmd_valid == 1'b0 && busy == 1'b0, "R9", 64'({cmd_valid, busy}), 64'd0);
      rd(8'h18, d); check(d == 0, "R9", 64'(d), 64'd0);

      // R8 writes ignored while busy
      wr(8'h18, 32'd4);
      wr(8'h08, 32'h0BAD_0BAD); wr(8'h1C, 32'h8000_0000);
      rd(8'h08, d); check(d == A[31:0], "R8", 64'(d), 64'(A[31:0]));
      rd(8'h1C, d); check(d == 32'h0, "R8", 64'(d), 64'd0);
      run_and_check(4, 1'b0, 0);

      // R10 restart in the middle of a triple-mode frame
      wr(8'h1C, 32'h8000_0000);
      rd(8'h1C, d); check(d == 32'h8000_0000, "R5", 64'(d), 64'h8000_0000);
      wr(8'h18, 32'd9);
      consume(2);
      check(cmd_word == B, "R5", cmd_word, B);
      wr(8'h18, 32'd5);
      check(cmd_word == A, "R10", cmd_word, A);
      rd(8'h18, d); check(d == 5, "R10", 64'(d), 64'd5);
      run_and_check(5, 1'b1, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule